// File: doc/BRIEF.md
# Two-Bit-Per-Clock Output Register Cell

This cell drives one output pin with two bits in every clock period. It takes a single clock. A register on the rising edge holds the first bit. A register on the falling edge holds the second bit, and it is clocked by an inverted copy of the clock made inside the cell. The clock level itself steers the output multiplexer, so nothing outside the cell drives a select. During the high phase the pin carries the first bit, and during the low phase it carries the second.

The cell contains two identical lanes. The data lane has its own clock enable. The three-state control lane has a separate clock enable. Both lanes share one synchronous set/reset input.

A parameter selects one of two alignment modes:

- **Split mode:** the second bit is sampled on the falling edge.
- **Rise-aligned mode:** both bits are sampled on the rising edge, and an internal stage hands the second bit to the falling-edge register half a cycle later.

A second parameter removes all registers and wires the first-bit inputs straight to the outputs.

Top module: `odr_cell`

## Requirements
- R1: On power-up each lane's output registers hold the value given by that lane's INIT parameter (INIT_DAT for the data lane, INIT_TRI for the three-state lane). The output shows this value until the first enabled edge.
- R2: While clk_i is high, a lane output shows its rising-edge register. While clk_i is low, it shows its falling-edge register. The A-input bit therefore precedes the B-input bit within each period.
- R3: In split mode (ALIGN = ALIGN_SPLIT, encoding 0), the A input is captured on the rising edge and the B input is captured on the following falling edge.
- R4: In rise-aligned mode (ALIGN = ALIGN_RISE, encoding 1), A and B are both captured on the rising edge. The captured B appears during the next low phase, even if the B input changes after that rising edge.
- R5: While a lane's clock enable is low and set/reset is low, all of that lane's registers keep their values.
- R6: The set/reset input acts synchronously on every register of both lanes and overrides the clock enables. With SR_IS_SET = 1 it loads all ones; with SR_IS_SET = 0 it loads all zeros.
- R7: The three-state lane (tri_a_i, tri_b_i, tri_o) behaves exactly like the data lane but is gated by tri_ce_i. The data lane is gated only by dat_ce_i.
- R8: With REGISTERED = 0, dat_o equals dat_a_i and tri_o equals tri_a_i combinationally, and the clock has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Single clock; its level selects the output bit |
| srst_i | input | 1 | Synchronous set/reset for both lanes, overrides the enables |
| dat_ce_i | input | 1 | Clock enable of the data lane |
| dat_a_i | input | W | Data bit sent during the high phase |
| dat_b_i | input | W | Data bit sent during the low phase |
| tri_ce_i | input | 1 | Clock enable of the three-state lane |
| tri_a_i | input | W | Three-state control sent during the high phase |
| tri_b_i | input | W | Three-state control sent during the low phase |
| dat_o | output | W | Double-rate data output |
| tri_o | output | W | Double-rate three-state control output |

## Verification
A wrong value in the rising-edge register shows on the pin during the very next high phase. A wrong value in the falling-edge register, or in the rise-aligned hand-off stage, shows during the next low phase, which is half a cycle later. Because of this, the bench samples both phases of every period. It also changes B between the rising and falling edges, so the two alignment modes can be told apart. An enable or set/reset fault corrupts both phases of the period that follows it, and every vector's check exposes such a fault within one clock.

// File: rtl/odr_pkg.sv
package odr_pkg;

    typedef enum logic {
        ALIGN_SPLIT = 1'b0,
        ALIGN_RISE  = 1'b1
    } odr_align_e;

    localparam int ODR_LANES = 2;
    localparam int LANE_DAT  = 0;
    localparam int LANE_TRI  = 1;

endpackage

// File: rtl/odr_edge_reg.sv
module odr_edge_reg #(
    parameter int           W         = 1,
    parameter bit           SR_IS_SET = 1'b0,
    parameter logic [W-1:0] INIT      = '0
) (
    input  logic         ck_i,
    input  logic         ce_i,
    input  logic         sr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    localparam logic [W-1:0] SR_VAL = SR_IS_SET ? {W{1'b1}} : {W{1'b0}};

    typedef struct packed {
        logic [W-1:0] val;
    } edge_st_t;

    edge_st_t st_d;
    edge_st_t st_q = edge_st_t'(INIT);

    always_comb begin
        st_d = st_q;
        if (sr_i) begin
            st_d.val = SR_VAL;
        end else if (ce_i) begin
            st_d.val = d_i;
        end
    end

    always_ff @(posedge ck_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.val;

    // R6: set/reset wins over enable
    assert_sr_load_R6: assert property (@(posedge ck_i) sr_i |=> (q_o == SR_VAL))
        else $error("set/reset did not load the register");

    // R5: disabled register keeps its value
    assert_hold_R5: assert property (@(posedge ck_i) (!sr_i && !ce_i) |=> $stable(q_o))
        else $error("register changed while disabled");

    // R3: enabled register captures its input
    assert_capture_R3: assert property (@(posedge ck_i) (!sr_i && ce_i) |=> (q_o == $past(d_i)))
        else $error("register missed an enabled capture");

endmodule

// File: rtl/odr_lane.sv
module odr_lane
    import odr_pkg::*;
#(
    parameter int           W          = 1,
    parameter odr_align_e   ALIGN      = ALIGN_RISE,
    parameter bit           REGISTERED = 1'b1,
    parameter bit           SR_IS_SET  = 1'b0,
    parameter logic [W-1:0] INIT       = '0
) (
    input  logic         clk_i,
    input  logic         ce_i,
    input  logic         sr_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] q_o
);

    generate
        if (REGISTERED) begin : g_reg
            logic         clk_n;
            logic [W-1:0] rise_q;
            logic [W-1:0] fall_q;
            logic [W-1:0] fall_src;

            assign clk_n = ~clk_i;

            odr_edge_reg #(.W(W), .SR_IS_SET(SR_IS_SET), .INIT(INIT)) u_rise (
                .ck_i (clk_i),
                .ce_i (ce_i),
                .sr_i (sr_i),
                .d_i  (a_i),
                .q_o  (rise_q)
            );

            if (ALIGN == ALIGN_RISE) begin : g_rise_align
                logic [W-1:0] stage_q;

                odr_edge_reg #(.W(W), .SR_IS_SET(SR_IS_SET), .INIT(INIT)) u_stage (
                    .ck_i (clk_i),
                    .ce_i (ce_i),
                    .sr_i (sr_i),
                    .d_i  (b_i),
                    .q_o  (stage_q)
                );
                assign fall_src = stage_q;

                // R4: falling register takes the bit staged on the rising edge
                assert_stage_handoff_R4: assert property (@(negedge clk_i)
                    (!sr_i && ce_i) |=> (fall_q == $past(stage_q)))
                    else $error("staged bit not handed to falling register");
            end else begin : g_split_align
                assign fall_src = b_i;
            end

            odr_edge_reg #(.W(W), .SR_IS_SET(SR_IS_SET), .INIT(INIT)) u_fall (
                .ck_i (clk_n),
                .ce_i (ce_i),
                .sr_i (sr_i),
                .d_i  (fall_src),
                .q_o  (fall_q)
            );

            assign q_o = clk_i ? rise_q : fall_q;
        end else begin : g_bypass
            assign q_o = a_i;
        end
    endgenerate

endmodule

// File: rtl/odr_cell.sv
module odr_cell
    import odr_pkg::*;
#(
    parameter int           W          = 1,
    parameter odr_align_e   ALIGN      = ALIGN_RISE,
    parameter bit           REGISTERED = 1'b1,
    parameter bit           SR_IS_SET  = 1'b0,
    parameter logic [W-1:0] INIT_DAT   = '0,
    parameter logic [W-1:0] INIT_TRI   = '0
) (
    input  logic         clk_i,
    input  logic         srst_i,
    input  logic         dat_ce_i,
    input  logic [W-1:0] dat_a_i,
    input  logic [W-1:0] dat_b_i,
    input  logic         tri_ce_i,
    input  logic [W-1:0] tri_a_i,
    input  logic [W-1:0] tri_b_i,
    output logic [W-1:0] dat_o,
    output logic [W-1:0] tri_o
);

    logic [ODR_LANES-1:0]        ce_v;
    logic [ODR_LANES-1:0][W-1:0] a_v;
    logic [ODR_LANES-1:0][W-1:0] b_v;
    logic [ODR_LANES-1:0][W-1:0] q_v;

    assign ce_v[LANE_DAT] = dat_ce_i;
    assign ce_v[LANE_TRI] = tri_ce_i;
    assign a_v[LANE_DAT]  = dat_a_i;
    assign a_v[LANE_TRI]  = tri_a_i;
    assign b_v[LANE_DAT]  = dat_b_i;
    assign b_v[LANE_TRI]  = tri_b_i;

    generate
        for (genvar g = 0; g < ODR_LANES; g++) begin : g_lane
            localparam logic [W-1:0] LANE_INIT = (g == LANE_DAT) ? INIT_DAT : INIT_TRI;

            odr_lane #(
                .W          (W),
                .ALIGN      (ALIGN),
                .REGISTERED (REGISTERED),
                .SR_IS_SET  (SR_IS_SET),
                .INIT       (LANE_INIT)
            ) u_lane (
                .clk_i (clk_i),
                .ce_i  (ce_v[g]),
                .sr_i  (srst_i),
                .a_i   (a_v[g]),
                .b_i   (b_v[g]),
                .q_o   (q_v[g])
            );
        end
    endgenerate

    assign dat_o = q_v[LANE_DAT];
    assign tri_o = q_v[LANE_TRI];

endmodule

// File: tb/odr_cell_tb_top.sv
module odr_cell_tb_top;
    import odr_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic sr, dce, tce, a, b;
    logic q_r, t_r, q_s, t_s, q_b, t_b;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // three-state inputs are the data inputs swapped
    odr_cell #(.W(1), .ALIGN(ALIGN_RISE), .REGISTERED(1'b1), .SR_IS_SET(1'b0),
               .INIT_DAT(1'b1), .INIT_TRI(1'b0)) dut_i (
        .clk_i(clk), .srst_i(sr), .dat_ce_i(dce), .dat_a_i(a), .dat_b_i(b),
        .tri_ce_i(tce), .tri_a_i(b), .tri_b_i(a), .dat_o(q_r), .tri_o(t_r));

    odr_cell #(.W(1), .ALIGN(ALIGN_SPLIT), .REGISTERED(1'b1), .SR_IS_SET(1'b1),
               .INIT_DAT(1'b0), .INIT_TRI(1'b1)) dut_opp_i (
        .clk_i(clk), .srst_i(sr), .dat_ce_i(dce), .dat_a_i(a), .dat_b_i(b),
        .tri_ce_i(tce), .tri_a_i(b), .tri_b_i(a), .dat_o(q_s), .tri_o(t_s));

    odr_cell #(.W(1), .ALIGN(ALIGN_RISE), .REGISTERED(1'b0), .SR_IS_SET(1'b0),
               .INIT_DAT(1'b0), .INIT_TRI(1'b0)) dut_byp_i (
        .clk_i(clk), .srst_i(sr), .dat_ce_i(dce), .dat_a_i(a), .dat_b_i(b),
        .tri_ce_i(tce), .tri_a_i(b), .tri_b_i(a), .dat_o(q_b), .tri_o(t_b));

    // {a, b, ce, sr, dat_hi, dat_lo, tri_hi, tri_lo} for a clear-type set/reset
    localparam logic [7:0] VEC [10] = '{
        8'b1010_1001, 8'b0110_0110, 8'b1110_1111, 8'b0000_1111, 8'b0100_1111,
        8'b0111_0000, 8'b1101_0000, 8'b1010_1001, 8'b0010_0000, 8'b0110_0110
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        sr = 0; dce = 0; tce = 0; a = 0; b = 0;
        // R1: enables low in the first period, INIT must still show
        @(posedge clk); #2;
        chk("R1", "dat hi rise-mode", q_r, 1'b1);
        chk("R1", "tri hi rise-mode", t_r, 1'b0);
        chk("R1", "dat hi split-mode", q_s, 1'b0);
        chk("R1", "tri hi split-mode", t_s, 1'b1);
        @(negedge clk); #2;
        chk("R1", "dat lo rise-mode", q_r, 1'b1);
        chk("R1", "tri lo split-mode", t_s, 1'b1);
        #1;

        // Table: R2, R3, R4, R5, R6, R7 in both modes, R8 on the bypass copy
        for (int i = 0; i < 10; i++) begin
            logic [7:0] v;
            logic sx;
            v = VEC[i];
            {a, b, dce, sr} = v[7:4];
            tce = v[5];
            sx = v[4];
            @(posedge clk); #2;
            chk("R2", "dat hi rise-mode", q_r, v[3]);
            chk("R7", "tri hi rise-mode", t_r, v[1]);
            chk("R6", "dat hi split-mode", q_s, sx ? 1'b1 : v[3]);
            chk("R7", "tri hi split-mode", t_s, sx ? 1'b1 : v[1]);
            chk("R8", "bypass dat", q_b, a);
            chk("R8", "bypass tri", t_b, b);
            @(negedge clk); #2;
            chk("R2", "dat lo rise-mode", q_r, v[2]);
            chk("R7", "tri lo rise-mode", t_r, v[0]);
            chk("R3", "dat lo split-mode", q_s, sx ? 1'b1 : v[2]);
            chk("R7", "tri lo split-mode", t_s, sx ? 1'b1 : v[0]);
            chk("R8", "bypass dat lo", q_b, a);
            #1;
        end

        // R3/R4: B changes after the rising edge, before the falling edge
        a = 1; b = 0; dce = 1; tce = 1; sr = 0;
        @(posedge clk); #1;
        b = 1;
        #1;
        chk("R4", "dat hi rise-mode", q_r, 1'b1);
        chk("R3", "dat hi split-mode", q_s, 1'b1);
        @(negedge clk); #2;
        chk("R4", "dat lo keeps old B", q_r, 1'b0);
        chk("R3", "dat lo takes new B", q_s, 1'b1);
        #1;

        // R7: three-state enable low while data enable high
        a = 0; b = 1; dce = 1; tce = 0;
        @(posedge clk); #2;
        chk("R7", "dat hi", q_r, 1'b0);
        chk("R7", "tri hi held", t_r, 1'b0);
        chk("R7", "tri hi held split", t_s, 1'b0);
        @(negedge clk); #2;
        chk("R7", "dat lo", q_r, 1'b1);
        chk("R7", "tri lo held", t_r, 1'b1);
        chk("R7", "tri lo held split", t_s, 1'b1);
        #1;

        // R5/R6: set/reset with both enables low still loads
        a = 1; b = 1; dce = 0; tce = 0; sr = 1;
        @(posedge clk); #2;
        chk("R6", "clear hi", q_r, 1'b0);
        chk("R6", "set hi", q_s, 1'b1);
        @(negedge clk); #2;
        chk("R6", "clear lo", t_r, 1'b0);
        chk("R6", "set lo", t_s, 1'b1);
        #1;
        sr = 0;
        @(posedge clk); #2;
        chk("R5", "hold after clear", q_r, 1'b0);
        @(negedge clk); #2;
        chk("R5", "hold lo after set", q_s, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule